// File: doc/BRIEF.md
# Floating-point exponent and shift datapath

This block holds two registers for a floating-point unit: the working result exponent and the working shift count. On every clock, a sequencer drives select and negate controls. Each register's next value is the sum of two operands, and each operand is taken from its own fixed menu. Either operand may be negated, but only one at a time. The sequencer can also load the shift register straight from a leading-zero count of a 64-bit mantissa. That count skips the adder entirely, so the adder stays off its path.

All exponent and shift values are 13-bit two's-complement numbers. Sums wrap modulo 2^13. The sequencer updates the result exponent only when it asks to. It rewrites the shift register on every clock, so holding the shift means selecting "current shift plus constant zero".

Top module: `fexp_datapath`

## Requirements
- R1: While `rst_n` is low, `res_exp` and `shift` both read zero.
- R2: When `re_load` is 1, the next `res_exp` is the 13-bit two's-complement sum (mod 2^13) of operand 1 and operand 2. Operand 1 is negated when `re_inv1` is 1, and operand 2 is negated when `re_inv2` is 1.
- R3: Result operand 1 is chosen by `re_pick1`: 0 = current result exponent, 1 = `exp_a`, 2 = `exp_b` arithmetically shifted right by one, 3 = zero.
- R4: Result operand 2 is chosen by `re_pick2`: 0 = current result exponent minus current shift, 1 = `exp_b`, 2 = `exp_c`, 3 = the constant picked by `re_const`.
- R5: `re_const` picks the constant: 0 = 0, 1 = 56, 2 = 1023 (largest exponent), 3 = 1536 (overflow trap bias).
- R6: When `re_load` is 0, `res_exp` keeps its value.
- R7: When `sh_lzc` is 0, the next `shift` is the sum of shift operand 1 and shift operand 2, each negated by `sh_inv1` or `sh_inv2`. `sh_pick1` picks operand 1: 0 = result exponent minus shift, 1 = `exp_b`, 2 = current shift, 3 = zero. `sh_pick2` picks operand 2: 0 = `exp_a`, 1 = the constant picked by `sh_const`.
- R8: `sh_const` picks the shift constant: 0→0, 1→1, 2→4, 3→8, 4→32, 5→52, 6→56, 7→63, 8→64, 9→−1022 (smallest exponent), 10..15→0.
- R9: When `sh_lzc` is 1, the next `shift` is the number of zero bits above the highest set bit of `mant_r`. Bit 63 set gives 0, and an all-zero `mant_r` gives 64. The adder controls have no effect in this case.
- R10: The sequencer never asserts both negate bits of the same adder in one cycle. Such a combination is flagged as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_a | input | 13 | Exponent of operand A (signed) |
| exp_b | input | 13 | Exponent of operand B (signed) |
| exp_c | input | 13 | Exponent of operand C (signed) |
| mant_r | input | 64 | Mantissa for leading-zero counting |
| re_pick1 | input | 2 | Result operand 1 select |
| re_inv1 | input | 1 | Negate result operand 1 |
| re_pick2 | input | 2 | Result operand 2 select |
| re_const | input | 2 | Result constant select |
| re_inv2 | input | 1 | Negate result operand 2 |
| re_load | input | 1 | Write enable for the result exponent |
| sh_pick1 | input | 2 | Shift operand 1 select |
| sh_inv1 | input | 1 | Negate shift operand 1 |
| sh_pick2 | input | 1 | Shift operand 2 select |
| sh_const | input | 4 | Shift constant select |
| sh_inv2 | input | 1 | Negate shift operand 2 |
| sh_lzc | input | 1 | Load shift from the leading-zero count |
| res_exp | output | 13 | Registered result exponent (signed) |
| shift | output | 13 | Registered shift count (signed) |

## Verification
The bench targets these corner cases:
- **Halving a negative B exponent.** A design that shifts logically, rather than arithmetically, turns a small negative value into a large positive one.
- **The difference operand.** It must use the register values from before the edge. A design that reads freshly written values, or subtracts in the wrong order, gives values off by the shift.
- **Leading-zero counting.** The bench tries an all-zero mantissa, a set top bit, a set bottom bit and single bits at several positions. An off-by-one counter, or one that counts from the wrong end, shows up immediately. So does a count routed through the adder, which would wrongly apply the operand negation.
- **Load-disabled cycles and every constant index.** These expose a result register that updates without `re_load` and any wrong entry in a constant menu, including the unused indices and the negative minimum exponent.

// File: rtl/fexp_pkg.sv
package fexp_pkg;

    // Operand menu of the first result-exponent input
    typedef enum logic [1:0] {
        RE1_RES   = 2'd0,
        RE1_A     = 2'd1,
        RE1_BHALF = 2'd2,
        RE1_ZERO  = 2'd3
    } re_src1_e;

    // Operand menu of the second result-exponent input
    typedef enum logic [1:0] {
        RE2_DIFF  = 2'd0,
        RE2_B     = 2'd1,
        RE2_C     = 2'd2,
        RE2_CONST = 2'd3
    } re_src2_e;

    // Constant menu of the result-exponent adder
    typedef enum logic [1:0] {
        REK_ZERO = 2'd0,
        REK_56   = 2'd1,
        REK_MAX  = 2'd2,
        REK_BIAS = 2'd3
    } re_const_e;

    // Operand menu of the first shift input
    typedef enum logic [1:0] {
        SH1_DIFF  = 2'd0,
        SH1_B     = 2'd1,
        SH1_SHIFT = 2'd2,
        SH1_ZERO  = 2'd3
    } sh_src1_e;

    // Operand menu of the second shift input
    typedef enum logic {
        SH2_A     = 1'b0,
        SH2_CONST = 1'b1
    } sh_src2_e;

    // Fixed (width independent) shift constants
    localparam int SHK_VAL1 = 1;
    localparam int SHK_VAL2 = 4;
    localparam int SHK_VAL3 = 8;
    localparam int SHK_VAL4 = 32;
    localparam int SHK_VAL5 = 52;
    localparam int SHK_VAL6 = 56;
    localparam int SHK_VAL7 = 63;
    localparam int SHK_VAL8 = 64;
    localparam int REK_VAL1 = 56;

endpackage

// File: rtl/fexp_addsub.sv
module fexp_addsub #(
    parameter int W = 13
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    input  logic                inv_a,
    input  logic                inv_b,
    output logic signed [W-1:0] sum
);

    logic signed [W-1:0] term_a;
    logic signed [W-1:0] term_b;

    always_comb begin
        term_a = inv_a ? -op_a : op_a;
        term_b = inv_b ? -op_b : op_b;
        sum    = term_a + term_b;
    end

endmodule

// File: rtl/fexp_lzc.sv
module fexp_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    // Scan upward; the highest set bit is the last one written.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fexp_datapath.sv
module fexp_datapath
    import fexp_pkg::*;
#(
    parameter int EXP_W    = 13,
    parameter int MANT_W   = 64,
    parameter int EXP_MAX  = 1023,
    parameter int EXP_MIN  = -1022,
    parameter int OVF_BIAS = 1536
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [EXP_W-1:0] exp_a,
    input  logic signed [EXP_W-1:0] exp_b,
    input  logic signed [EXP_W-1:0] exp_c,
    input  logic [MANT_W-1:0]       mant_r,
    input  logic [1:0]              re_pick1,
    input  logic                    re_inv1,
    input  logic [1:0]              re_pick2,
    input  logic [1:0]              re_const,
    input  logic                    re_inv2,
    input  logic                    re_load,
    input  logic [1:0]              sh_pick1,
    input  logic                    sh_inv1,
    input  logic                    sh_pick2,
    input  logic [3:0]              sh_const,
    input  logic                    sh_inv2,
    input  logic                    sh_lzc,
    output logic signed [EXP_W-1:0] res_exp,
    output logic signed [EXP_W-1:0] shift
);

    localparam int CNT_W = $clog2(MANT_W + 1);
    localparam int PAD_W = EXP_W - CNT_W;

    localparam logic signed [EXP_W-1:0] K_MAX  = EXP_W'(EXP_MAX);
    localparam logic signed [EXP_W-1:0] K_MIN  = EXP_W'(EXP_MIN);
    localparam logic signed [EXP_W-1:0] K_BIAS = EXP_W'(OVF_BIAS);
    localparam logic signed [EXP_W-1:0] K_RE56 = EXP_W'(REK_VAL1);

    logic signed [EXP_W-1:0] res_q;
    logic signed [EXP_W-1:0] shift_q;
    logic signed [EXP_W-1:0] diff_exp;
    logic signed [EXP_W-1:0] re_op1;
    logic signed [EXP_W-1:0] re_op2;
    logic signed [EXP_W-1:0] re_kval;
    logic signed [EXP_W-1:0] re_sum;
    logic signed [EXP_W-1:0] sh_op1;
    logic signed [EXP_W-1:0] sh_op2;
    logic signed [EXP_W-1:0] sh_kval;
    logic signed [EXP_W-1:0] sh_sum;
    logic signed [EXP_W-1:0] shift_d;
    logic [CNT_W-1:0]        lz_count;

    // Exponent minus shift, shared by both operand menus
    always_comb begin
        diff_exp = res_q - shift_q;
    end

    // Result-exponent operand 1
    always_comb begin
        unique case (re_src1_e'(re_pick1))
            RE1_RES:   re_op1 = res_q;
            RE1_A:     re_op1 = exp_a;
            RE1_BHALF: re_op1 = exp_b >>> 1;
            RE1_ZERO:  re_op1 = '0;
        endcase
    end

    // Result-exponent constant
    always_comb begin
        unique case (re_const_e'(re_const))
            REK_ZERO: re_kval = '0;
            REK_56:   re_kval = K_RE56;
            REK_MAX:  re_kval = K_MAX;
            REK_BIAS: re_kval = K_BIAS;
        endcase
    end

    // Result-exponent operand 2
    always_comb begin
        unique case (re_src2_e'(re_pick2))
            RE2_DIFF:  re_op2 = diff_exp;
            RE2_B:     re_op2 = exp_b;
            RE2_C:     re_op2 = exp_c;
            RE2_CONST: re_op2 = re_kval;
        endcase
    end

    fexp_addsub #(.W(EXP_W)) u_re_add (
        .op_a  (re_op1),
        .op_b  (re_op2),
        .inv_a (re_inv1),
        .inv_b (re_inv2),
        .sum   (re_sum)
    );

    // Shift operand 1
    always_comb begin
        unique case (sh_src1_e'(sh_pick1))
            SH1_DIFF:  sh_op1 = diff_exp;
            SH1_B:     sh_op1 = exp_b;
            SH1_SHIFT: sh_op1 = shift_q;
            SH1_ZERO:  sh_op1 = '0;
        endcase
    end

    // Shift constant
    always_comb begin
        unique case (sh_const)
            4'd1:    sh_kval = EXP_W'(SHK_VAL1);
            4'd2:    sh_kval = EXP_W'(SHK_VAL2);
            4'd3:    sh_kval = EXP_W'(SHK_VAL3);
            4'd4:    sh_kval = EXP_W'(SHK_VAL4);
            4'd5:    sh_kval = EXP_W'(SHK_VAL5);
            4'd6:    sh_kval = EXP_W'(SHK_VAL6);
            4'd7:    sh_kval = EXP_W'(SHK_VAL7);
            4'd8:    sh_kval = EXP_W'(SHK_VAL8);
            4'd9:    sh_kval = K_MIN;
            default: sh_kval = '0;
        endcase
    end

    // Shift operand 2
    always_comb begin
        unique case (sh_src2_e'(sh_pick2))
            SH2_A:     sh_op2 = exp_a;
            SH2_CONST: sh_op2 = sh_kval;
        endcase
    end

    fexp_addsub #(.W(EXP_W)) u_sh_add (
        .op_a  (sh_op1),
        .op_b  (sh_op2),
        .inv_a (sh_inv1),
        .inv_b (sh_inv2),
        .sum   (sh_sum)
    );

    fexp_lzc #(.W(MANT_W), .CW(CNT_W)) u_lzc (
        .vec   (mant_r),
        .count (lz_count)
    );

    // Normalisation count joins after the adder
    always_comb begin
        shift_d = sh_lzc ? $signed({{PAD_W{1'b0}}, lz_count}) : sh_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            shift_q <= '0;
        end else begin
            if (re_load) begin
                res_q <= re_sum;
            end
            shift_q <= shift_d;
        end
    end

    assign res_exp = res_q;
    assign shift   = shift_q;

endmodule

// File: rtl/fexp_datapath_chk.sv
module fexp_datapath_chk #(
    parameter int EXP_W  = 13,
    parameter int MANT_W = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [MANT_W-1:0]       mant_r,
    input logic [1:0]              re_pick1,
    input logic                    re_inv1,
    input logic [1:0]              re_pick2,
    input logic [1:0]              re_const,
    input logic                    re_inv2,
    input logic                    re_load,
    input logic [1:0]              sh_pick1,
    input logic                    sh_inv1,
    input logic                    sh_pick2,
    input logic [3:0]              sh_const,
    input logic                    sh_inv2,
    input logic                    sh_lzc,
    input logic signed [EXP_W-1:0] res_exp,
    input logic signed [EXP_W-1:0] shift
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (res_exp == '0 && shift == '0));

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_load |=> $stable(res_exp));

    // R2
    res_zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re_load && re_pick1 == 2'd3 && re_pick2 == 2'd3 && re_const == 2'd0)
        |=> res_exp == '0);

    // R7
    shift_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_lzc && sh_pick1 == 2'd2 && sh_pick2 && sh_const == 4'd0 && !sh_inv1)
        |=> $stable(shift));

    // R9
    lzc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_lzc && mant_r == '0) |=> shift == EXP_W'(MANT_W));

    // R9
    lzc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_lzc && mant_r[MANT_W-1]) |=> shift == '0);

    // R10
    re_one_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(re_inv1 && re_inv2));

    // R10
    sh_one_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_inv1 && sh_inv2));

endmodule

bind fexp_datapath fexp_datapath_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mant_r   (mant_r),
    .re_pick1 (re_pick1),
    .re_inv1  (re_inv1),
    .re_pick2 (re_pick2),
    .re_const (re_const),
    .re_inv2  (re_inv2),
    .re_load  (re_load),
    .sh_pick1 (sh_pick1),
    .sh_inv1  (sh_inv1),
    .sh_pick2 (sh_pick2),
    .sh_const (sh_const),
    .sh_inv2  (sh_inv2),
    .sh_lzc   (sh_lzc),
    .res_exp  (res_exp),
    .shift    (shift)
);

// File: tb/fexp_datapath_test.sv
module fexp_datapath_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [12:0] exp_a = '0, exp_b = '0, exp_c = '0;
    logic [63:0]        mant_r = '0;
    logic [1:0]         re_pick1 = '0, re_pick2 = '0, re_const = '0;
    logic               re_inv1 = 1'b0, re_inv2 = 1'b0, re_load = 1'b0;
    logic [1:0]         sh_pick1 = '0;
    logic               sh_pick2 = 1'b0, sh_inv1 = 1'b0, sh_inv2 = 1'b0, sh_lzc = 1'b0;
    logic [3:0]         sh_const = '0;
    logic signed [12:0] res_exp, shift;

    int checks = 0;
    int errors = 0;
    int m_res  = 0;
    int m_sh   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fexp_datapath uut (
        .clk(clk), .rst_n(rst_n), .exp_a(exp_a), .exp_b(exp_b), .exp_c(exp_c),
        .mant_r(mant_r), .re_pick1(re_pick1), .re_inv1(re_inv1), .re_pick2(re_pick2),
        .re_const(re_const), .re_inv2(re_inv2), .re_load(re_load),
        .sh_pick1(sh_pick1), .sh_inv1(sh_inv1), .sh_pick2(sh_pick2),
        .sh_const(sh_const), .sh_inv2(sh_inv2), .sh_lzc(sh_lzc),
        .res_exp(res_exp), .shift(shift)
    );

    function automatic int wrap13(int v);
        int t = v & 32'h1FFF;
        if (t >= 4096) t = t - 8192;
        return t;
    endfunction

    function automatic int lead_zeros(logic [63:0] v);
        int n = 0;
        bit seen = 1'b0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) seen = 1'b1;
            else if (!seen) n++;
        end
        return n;
    endfunction

    function automatic int re_k(int sel);
        case (sel)
            1: return 56;
            2: return 1023;
            3: return 1536;
            default: return 0;
        endcase
    endfunction

    function automatic int sh_k(int sel);
        case (sel)
            1: return 1;  2: return 4;  3: return 8;  4: return 32;
            5: return 52; 6: return 56; 7: return 63; 8: return 64;
            9: return -1022;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Called at a negedge with inputs already set; advances one clock.
    task automatic step(string re_tag, string sh_tag);
        int a, b, c, diff, o1, o2, n_res, n_sh;
        a = exp_a; b = exp_b; c = exp_c;
        diff = wrap13(m_res - m_sh);
        if ((re_inv1 && re_inv2) || (sh_inv1 && sh_inv2)) begin
            errors++;
            $display("FAIL R10 actual both-negate expected single-negate");
        end
        case (re_pick1)
            2'd0: o1 = m_res;
            2'd1: o1 = a;
            2'd2: o1 = b >>> 1;
            default: o1 = 0;
        endcase
        case (re_pick2)
            2'd0: o2 = diff;
            2'd1: o2 = b;
            2'd2: o2 = c;
            default: o2 = re_k(int'(re_const));
        endcase
        n_res = re_load ? wrap13((re_inv1 ? -o1 : o1) + (re_inv2 ? -o2 : o2)) : m_res;
        case (sh_pick1)
            2'd0: o1 = diff;
            2'd1: o1 = b;
            2'd2: o1 = m_sh;
            default: o1 = 0;
        endcase
        o2 = sh_pick2 ? sh_k(int'(sh_const)) : a;
        n_sh = sh_lzc ? lead_zeros(mant_r)
                      : wrap13((sh_inv1 ? -o1 : o1) + (sh_inv2 ? -o2 : o2));
        @(posedge clk);
        @(negedge clk);
        m_res = n_res;
        m_sh  = n_sh;
        check(re_tag, int'(res_exp), m_res);
        check(sh_tag, int'(shift), m_sh);
    endtask

    task automatic idle_ctl();
        re_pick1 = 2'd0; re_pick2 = 2'd3; re_const = 2'd0;
        re_inv1 = 1'b0; re_inv2 = 1'b0; re_load = 1'b0;
        sh_pick1 = 2'd2; sh_pick2 = 1'b1; sh_const = 4'd0;
        sh_inv1 = 1'b0; sh_inv2 = 1'b0; sh_lzc = 1'b0;
    endtask

    initial begin
        idle_ctl();
        repeat (3) @(negedge clk);
        check("R1", int'(res_exp), 0);
        check("R1", int'(shift), 0);
        rst_n = 1'b1;

        // R5: each result constant
        for (int k = 0; k < 4; k++) begin
            idle_ctl(); re_load = 1'b1; re_pick1 = 2'd3; re_pick2 = 2'd3;
            re_const = 2'(k);
            step("R5", "R7");
        end
        // R8: every shift constant index, including unused ones
        for (int k = 0; k < 16; k++) begin
            idle_ctl(); sh_pick1 = 2'd3; sh_const = 4'(k);
            step("R6", "R8");
        end
        // R3: halving a negative B, then an odd positive B
        idle_ctl(); re_load = 1'b1; re_pick1 = 2'd2; re_pick2 = 2'd3; exp_b = -13'sd7;
        step("R3", "R7");
        exp_b = 13'sd9;
        step("R3", "R7");
        // R4: result minus shift, with a nonzero shift
        idle_ctl(); sh_pick1 = 2'd3; sh_const = 4'd5; step("R6", "R8");
        idle_ctl(); re_load = 1'b1; re_pick1 = 2'd3; re_pick2 = 2'd0; step("R4", "R7");
        idle_ctl(); re_load = 1'b1; re_pick1 = 2'd1; re_pick2 = 2'd2; re_inv2 = 1'b1;
        exp_a = 13'sd100; exp_c = -13'sd300; step("R4", "R7");
        // R2: wrap-around past the positive limit
        idle_ctl(); re_load = 1'b1; re_pick1 = 2'd1; re_pick2 = 2'd1;
        exp_a = 13'sd4000; exp_b = 13'sd1000; step("R2", "R7");
        // R6: load disabled with busy operands
        idle_ctl(); re_pick1 = 2'd1; exp_a = 13'sd77; step("R6", "R7");
        // R7: shift = B - A, and negated difference
        idle_ctl(); sh_pick1 = 2'd1; sh_pick2 = 1'b0; sh_inv2 = 1'b1;
        exp_a = 13'sd20; exp_b = -13'sd5; step("R6", "R7");
        idle_ctl(); sh_pick1 = 2'd0; sh_inv1 = 1'b1; step("R6", "R7");
        // R9: leading-zero loads; adder controls set to disturb
        idle_ctl(); sh_lzc = 1'b1; sh_inv1 = 1'b1; sh_pick1 = 2'd1;
        mant_r = '0; step("R6", "R9");
        mant_r = 64'h8000_0000_0000_0000; step("R6", "R9");
        mant_r = 64'h1; step("R6", "R9");
        for (int p = 0; p < 64; p += 7) begin
            mant_r = 64'h1 << p; step("R6", "R9");
        end
        mant_r = 64'h0000_0F00_0000_1234; step("R6", "R9");

        // Random legal control sequences
        for (int n = 0; n < 3000; n++) begin
            bit neg1, neg2;
            exp_a = 13'($urandom); exp_b = 13'($urandom); exp_c = 13'($urandom);
            mant_r = {$urandom, $urandom} >> ($urandom % 64);
            re_pick1 = 2'($urandom); re_pick2 = 2'($urandom); re_const = 2'($urandom);
            neg1 = 1'($urandom); neg2 = 1'($urandom);
            re_inv1 = neg1; re_inv2 = neg2 & ~neg1;
            re_load = 1'($urandom);
            sh_pick1 = 2'($urandom); sh_pick2 = 1'($urandom); sh_const = 4'($urandom);
            neg1 = 1'($urandom); neg2 = 1'($urandom);
            sh_inv1 = neg1; sh_inv2 = neg2 & ~neg1;
            sh_lzc = ($urandom % 4) == 0;
            step(re_load ? "R2" : "R6", sh_lzc ? "R9" : "R7");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule